// File: doc/BRIEF.md
# Receive Payload Alarm-Fill Controller

This block sits on the receive payload path. The path runs from the line framer towards the serial data output and the cell or packet logic further downstream. When an alarm or a loopback condition calls for it, the block replaces the received bits with unframed all-ones. Every bit is replaced, overhead positions included. The block also drives a second copy of the stream, a tap that feeds the transmit side during payload loopback.

A mode input selects one of two fill sources.

- **Framer-side source (mode 0).** It reacts to:
  - the software force bit;
  - a detected incoming alarm pattern;
  - loss of signal;
  - out-of-frame, but only after out-of-frame has persisted for a configurable number of timebase ticks. This gives the 2.5 ms qualification at the chosen tick rate.

  Its fill is also carried on the loopback tap.
- **Top-level source (mode 1).** It reacts at once to:
  - the software force bit;
  - loss of signal;
  - out-of-frame;
  - line loopback;
  - payload loopback.

  Its fill goes only downstream, and the tap keeps the received data.

Automatic triggering (every trigger except the software bit) is gated by an auto-enable flag. This flag is set by reset and must be cleared through a configuration write.

Top module: `rx_ais_fill`

## Requirements
- R1: In mode 0, the fill is active when the force bit is high, or when auto-enable is set and any of these holds: the alarm-detect input is high, loss of signal is high, or the qualified out-of-frame is high. Line loopback and payload loopback have no effect in mode 0.
- R2: In mode 1, the fill is active when the force bit is high, or when auto-enable is set and any of these is high: loss of signal, out-of-frame, line loopback, payload loopback. Out-of-frame acts with no qualification, and the alarm-detect input has no effect.
- R3: With qualification enabled, the qualified out-of-frame rises only after out-of-frame has stayed high across PERSIST_TICKS timebase ticks. It rises in the cycle after the clock edge that samples the last of those ticks.
- R4: The persistence count returns to zero on any cycle in which out-of-frame is low, so a dropout before expiry restarts the full wait.
- R5: Both outputs are registered once. In the cycle after a clock edge at which the fill was active, the downstream output is all ones (every bit of the DW-bit word). The first edge at which no trigger holds returns the output to the data sampled at that edge.
- R6: The loopback tap carries all ones only when the fill is active in mode 0. Otherwise it carries the received word with one cycle of delay.
- R7: Auto-enable is 1 after reset. A write strobe loads it from the configuration bit. While it is 0, only the force bit activates the fill.
- R8: During reset both outputs are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timebase clock-enable for the persistence count |
| rx_data_i | input | DW | Received payload word |
| los_i | input | 1 | Loss of signal |
| oof_i | input | 1 | Out-of-frame |
| ais_det_i | input | 1 | Incoming alarm pattern detected |
| llb_i | input | 1 | Line loopback active |
| plb_i | input | 1 | Payload loopback active |
| force_i | input | 1 | Software force of the fill |
| mode_i | input | 1 | 0 framer-side source, 1 top-level source |
| cfg_wr_i | input | 1 | Write strobe for auto-enable |
| cfg_auto_i | input | 1 | Auto-enable value to write |
| ds_data_o | output | DW | Downstream payload |
| lb_data_o | output | DW | Tap toward the transmit loopback path |

## Verification
Suppose the persistence count is off by one or fails to clear on a dropout. Then the all-ones fill in mode 0 appears one tick early or late, or appears after a broken out-of-frame run. This is visible on the first output word after the edge that samples the deciding tick. A wrong source decode or a stale auto-enable shows on the downstream and tap outputs one cycle after the offending input pattern. The bench compares both outputs against a reference every cycle, so any such divergence is reported at that cycle.

// File: rtl/rx_ais_pkg.sv
package rx_ais_pkg;
   typedef enum logic {
      SRC_FRAMER = 1'b0,
      SRC_TOPLVL = 1'b1
   } fill_src_e;
endpackage

// File: rtl/rx_ais_persist.sv
module rx_ais_persist #(
   parameter int TICKS   = 25,
   parameter bit QUAL_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic oof_i,
   output logic qual_o
);
   localparam int CW = $clog2(TICKS + 1);
   localparam logic [CW-1:0] LIM = CW'(TICKS);

   initial begin
      assert (TICKS >= 1) else $fatal(1, "TICKS must be at least 1");
   end

   generate
      if (QUAL_EN) begin : g_qual
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)                   cnt <= '0;
            else if (!oof_i)              cnt <= '0;
            else if (tick_i && cnt != LIM) cnt <= cnt + 1'b1;
         end
         assign qual_o = (cnt == LIM);

         // R4: a low out-of-frame clears the count on the next edge
         assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !oof_i |=> (cnt == '0));
         // R3: the count never passes its limit
         assert_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= LIM);
         // R3: qualification rises only on a sampled tick under out-of-frame
         assert_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(qual_o) |-> ($past(tick_i) && $past(oof_i)));
      end else begin : g_direct
         assign qual_o = oof_i;
      end
   endgenerate
endmodule

// File: rtl/rx_ais_trigger.sv
module rx_ais_trigger
   import rx_ais_pkg::*;
(
   input  fill_src_e mode_i,
   input  logic      auto_i,
   input  logic      force_i,
   input  logic      los_i,
   input  logic      oof_i,
   input  logic      oof_qual_i,
   input  logic      ais_det_i,
   input  logic      llb_i,
   input  logic      plb_i,
   output logic      act_o,
   output logic      tap_o
);
   logic frm_cond, top_cond;

   always_comb begin
      frm_cond = ais_det_i | los_i | oof_qual_i;
      top_cond = los_i | oof_i | llb_i | plb_i;
      unique case (mode_i)
         SRC_FRAMER: act_o = force_i | (auto_i & frm_cond);
         SRC_TOPLVL: act_o = force_i | (auto_i & top_cond);
         default:    act_o = force_i;
      endcase
      tap_o = act_o & (mode_i == SRC_FRAMER);
   end
endmodule

// File: rtl/rx_ais_outreg.sv
module rx_ais_outreg #(
   parameter int DW = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          act_i,
   input  logic          tap_i,
   input  logic [DW-1:0] data_i,
   output logic [DW-1:0] ds_o,
   output logic [DW-1:0] lb_o
);
   initial begin
      assert (DW >= 1) else $fatal(1, "DW must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ds_o <= '0;
         lb_o <= '0;
      end else begin
         ds_o <= act_i ? '1 : data_i;
         lb_o <= tap_i ? '1 : data_i;
      end
   end

   // R5: fill overwrites every bit one cycle later
   assert_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
      act_i |=> (ds_o == '1));
   // R5: no fill passes the word through unchanged
   assert_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !act_i |=> (ds_o == $past(data_i)));
   // R6: tap carries data whenever it is not filled
   assert_tap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !tap_i |=> (lb_o == $past(data_i)));
endmodule

// File: rtl/rx_ais_fill.sv
module rx_ais_fill
   import rx_ais_pkg::*;
#(
   parameter int DW            = 1,
   parameter int PERSIST_TICKS = 25,
   parameter bit QUAL_EN       = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic [DW-1:0] rx_data_i,
   input  logic          los_i,
   input  logic          oof_i,
   input  logic          ais_det_i,
   input  logic          llb_i,
   input  logic          plb_i,
   input  logic          force_i,
   input  logic          mode_i,
   input  logic          cfg_wr_i,
   input  logic          cfg_auto_i,
   output logic [DW-1:0] ds_data_o,
   output logic [DW-1:0] lb_data_o
);
   logic auto_q, oof_qual, act, tap;
   fill_src_e mode;

   assign mode = fill_src_e'(mode_i);

   always_ff @(posedge clk) begin
      if (!rst_n)        auto_q <= 1'b1;
      else if (cfg_wr_i) auto_q <= cfg_auto_i;
   end

   rx_ais_persist #(.TICKS(PERSIST_TICKS), .QUAL_EN(QUAL_EN)) u_persist (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .oof_i(oof_i), .qual_o(oof_qual)
   );

   rx_ais_trigger u_trig (
      .mode_i(mode), .auto_i(auto_q), .force_i(force_i), .los_i(los_i),
      .oof_i(oof_i), .oof_qual_i(oof_qual), .ais_det_i(ais_det_i),
      .llb_i(llb_i), .plb_i(plb_i), .act_o(act), .tap_o(tap)
   );

   rx_ais_outreg #(.DW(DW)) u_out (
      .clk(clk), .rst_n(rst_n), .act_i(act), .tap_i(tap),
      .data_i(rx_data_i), .ds_o(ds_data_o), .lb_o(lb_data_o)
   );

   // R1: software force always fills downstream
   assert_force_R1: assert property (@(posedge clk) disable iff (!rst_n)
      force_i |=> (ds_data_o == '1));
   // R2: top-level source reacts at once to a loopback with auto-enable set
   assert_loop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i && auto_q && (llb_i || plb_i)) |=> (ds_data_o == '1));
   // R7: a cleared flag and no force leave data untouched
   assert_auto_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_q && !force_i) |=> (ds_data_o == $past(rx_data_i)));
endmodule

// File: tb/rx_ais_fill_test.sv
module rx_ais_fill_test;
   localparam int DW = 4;
   localparam int NT = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 0, los = 0, oof = 0, ais = 0, llb = 0, plb = 0, frc = 0, mode = 0;
   logic cfg_wr = 0, cfg_auto = 0;
   logic [DW-1:0] dat = '0;
   logic [DW-1:0] ds, lb;

   int checks = 0;
   int errors = 0;
   int mcnt = 0;
   logic mauto = 1'b1;
   logic [DW-1:0] eds = '0, elb = '0;

   always #2.5 clk = ~clk;

   rx_ais_fill #(.DW(DW), .PERSIST_TICKS(NT), .QUAL_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_data_i(dat), .los_i(los),
      .oof_i(oof), .ais_det_i(ais), .llb_i(llb), .plb_i(plb), .force_i(frc),
      .mode_i(mode), .cfg_wr_i(cfg_wr), .cfg_auto_i(cfg_auto),
      .ds_data_o(ds), .lb_data_o(lb)
   );

   function automatic logic fill_on(input logic m, input logic au, input int cnt);
      logic trig;
      if (!m) trig = ais | los | (cnt == NT);
      else    trig = los | oof | llb | plb;
      return frc | (au & trig);
   endfunction

   task automatic compare(input string tag);
      checks++;
      if (ds !== eds || lb !== elb) begin
         errors++;
         $display("FAIL %s: ds=%h lb=%h expected ds=%h lb=%h", tag, ds, lb, eds, elb);
      end
   endtask

   task automatic step(input string tag);
      logic a;
      @(posedge clk);
      a   = fill_on(mode, mauto, mcnt);
      eds = a ? '1 : dat;
      elb = (a && !mode) ? '1 : dat;
      if (!oof) mcnt = 0;
      else if (tick && mcnt < NT) mcnt++;
      if (cfg_wr) mauto = cfg_auto;
      @(negedge clk);
      compare(tag);
   endtask

   task automatic clr();
      tick = 0; los = 0; oof = 0; ais = 0; llb = 0; plb = 0; frc = 0; cfg_wr = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      dat = 4'h5;
      repeat (3) @(negedge clk);
      eds = '0; elb = '0;
      compare("R8 reset");
      rst_n = 1'b1;

      // R7: flag is set out of reset, so los fills in mode 1
      mode = 1; los = 1; dat = 4'h0; step("R7 reset auto");
      // R2: immediate out-of-frame and loopback in mode 1; tap keeps data (R6)
      clr(); oof = 1; dat = 4'h3; step("R2 oof immediate");
      clr(); plb = 1; dat = 4'h0; step("R6 top tap");
      clr(); llb = 1; dat = 4'h9; step("R2 llb");
      clr(); ais = 1; dat = 4'h6; step("R2 ais ignored");
      // R5: release on first clear edge
      clr(); dat = 4'hA; step("R5 release");

      // R1: framer mode sources; fill on tap as well
      mode = 0;
      clr(); ais = 1; dat = 4'h2; step("R1 ais");
      clr(); llb = 1; plb = 1; dat = 4'h4; step("R1 loops ignored");
      clr(); los = 1; dat = 4'h0; step("R1 los");
      clr(); frc = 1; dat = 4'h1; step("R1 force");

      // R3: exactly NT ticks needed
      clr(); oof = 1;
      for (int i = 0; i < NT + 3; i++) begin
         tick = 1; dat = 4'h0; step("R3 persist");
         tick = 0; step("R3 persist");
      end
      // R4: dropout restarts the wait
      clr(); dat = 4'h7; step("R4 drop");
      oof = 1;
      for (int i = 0; i < NT - 1; i++) begin tick = 1; step("R4 partial"); end
      oof = 0; tick = 1; step("R4 dropout");
      oof = 1;
      for (int i = 0; i < NT - 1; i++) begin tick = 1; step("R4 restart"); end
      tick = 0; step("R4 not yet");
      tick = 1; step("R4 last tick");
      tick = 0; step("R3 qualified");

      // R7: clear flag, triggers ignored, force still works
      clr(); cfg_wr = 1; cfg_auto = 0; step("R7 write");
      clr(); los = 1; ais = 1; dat = 4'h0; step("R7 cleared");
      mode = 1; llb = 1; step("R7 cleared top");
      frc = 1; step("R7 force");
      clr(); cfg_wr = 1; cfg_auto = 1; step("R7 set");

      // random mix
      for (int i = 0; i < 4000; i++) begin
         clr();
         dat  = DW'($urandom);
         tick = ($urandom % 3) == 0;
         oof  = ($urandom % 16) != 0 ? oof : ~oof;
         if (($urandom % 5) == 0) oof = ($urandom % 4) != 0;
         los  = ($urandom % 12) == 0;
         ais  = ($urandom % 12) == 0;
         llb  = ($urandom % 12) == 0;
         plb  = ($urandom % 12) == 0;
         frc  = ($urandom % 20) == 0;
         if (($urandom % 50) == 0) mode = ~mode;
         cfg_wr = ($urandom % 100) == 0;
         cfg_auto = ($urandom % 3) != 0;
         step(mode ? "R2 random" : "R1 random");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule